// File: doc/BRIEF.md
# Synchronous Slave FIFO Write Master

This block sits on the FPGA side of a synchronous slave FIFO bus and pushes a video word stream into a USB bridge. Words arrive on a valid/ready stream with a frame-end marker. The block presents each accepted word on the bus data lines together with active-low select and write strobes. It writes only while the bridge's active-low DMA-ready flag shows ready for the addressed thread and the active-high link-ready input is high. Data only flows toward the bridge, so the read and output-enable strobes are held inactive.

The bridge drains data in fixed-size DMA buffers. The block counts words per buffer. A buffer closes either when it is full or when the frame-end marker arrives early; an early close raises the active-low packet-end strobe on the final write. After every buffer the block withholds writes for a guard window of `FLAG_LAG + 1` cycles, because the ready flag reaches it late. In interleave mode it also moves the 2-bit thread address between thread 0 and thread 1. In single-thread mode the address stays at thread 0. The bus word width is a parameter: 32 bits for the wide link, or a narrower link.

Top module: `sfifo_wr_master`

## Requirements
- R1: While reset is asserted and after its release, the select, write and packet-end strobes are high (inactive) and the thread address is 0.
- R2: The read strobe `rd_n` and output-enable strobe `oe_n` are high in every cycle.
- R3: A word is accepted only in a cycle where `flag_n` is low. When `flag_n` is high, `s_ready` is low and no write strobe follows. No word is lost or repeated across such pauses.
- R4: No word is accepted while `link_rdy` is low, so no transfer begins before the link is up.
- R5: Each word accepted at a clock edge appears on `fd` with `wr_n` and `cs_n` low for exactly the following cycle, in stream order. A cycle with no acceptance leaves `wr_n` and `cs_n` high.
- R6: When `s_last` is accepted on a word that is not the last word of a buffer, `pktend_n` is low for that word's write cycle only. `pktend_n` is high in all other cycles.
- R7: After the accept that closes a buffer, `s_ready` stays low for exactly `FLAG_LAG + 1` cycles, whatever the flag shows.
- R8: The address bus carries the thread number, with bit 1 the most significant, and bit 1 is always 0. With `ilv_en` high when a buffer closes, the next buffer goes to the other thread (0 and 1 alternate). With `ilv_en` low, the next buffer goes to thread 0. The address changes one cycle after the closing write, so it is stable during every write strobe.
- R9: A buffer holds `BUF_BYTES*8/DATA_W` words. The write that fills a buffer closes it without a packet-end strobe, including when `s_last` coincides with that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted at the next edge when valid |
| s_data | input | DATA_W | Stream word |
| s_last | input | 1 | Word is the last of a frame |
| ilv_en | input | 1 | Interleave buffers across threads 0 and 1 |
| link_rdy | input | 1 | Active-high link ready from the bridge |
| flag_n | input | 1 | Active-low DMA ready for the addressed thread |
| cs_n | output | 1 | Active-low chip select |
| wr_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low output enable, held high |
| rd_n | output | 1 | Active-low read strobe, held high |
| pktend_n | output | 1 | Active-low packet end |
| addr | output | 2 | Thread address, bit 1 most significant |
| fd | output | DATA_W | Bus data toward the bridge |

## Verification
On every cycle the embedded properties check the following:
- Each write strobe was preceded by a ready flag and a live link.
- Packet end is a single-cycle pulse that only comes with a write.
- Select accompanies every write.
- The address holds across back-to-back writes.
- Every closed buffer is followed by a guard cycle and the correct next thread.

The randomized and directed scenarios show the rest:
- Words come out in order, with none lost, across flag and link pauses.
- The guard window has the exact length `FLAG_LAG + 1`.
- Packet end appears on early frame ends but not on a frame end that lands on the buffer's last word.
- Buffers alternate or stay on thread 0 according to the mode at each boundary.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_GUARD = 1'b1
  } sfw_state_e;

  // width of a counter able to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sfw_buf_ctr.sv
module sfw_buf_ctr #(
  parameter int unsigned BUF_WORDS = 16128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic last_in,
  output logic buf_end,
  output logic short_end
);
  import sfw_pkg::*;

  localparam int unsigned CW = cnt_width(BUF_WORDS - 1);
  localparam logic [CW-1:0] TOP = CW'(BUF_WORDS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_top;

  assign at_top    = (cnt_q == TOP);
  assign buf_end   = acc && (at_top || last_in);
  assign short_end = acc && last_in && !at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (buf_end)  cnt_d = '0;
    else if (acc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (acc) cnt_q <= cnt_d;
  end

  // R9: word count never passes the buffer size
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  // R9: a buffer never wraps without closing
  p_wrap_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && at_top) |=> (cnt_q == '0));
endmodule

// File: rtl/sfw_thread_sel.sv
module sfw_thread_sel #(
  parameter int unsigned FLAG_LAG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       buf_end,
  input  logic       ilv_en,
  output logic       run,
  output logic [1:0] addr
);
  import sfw_pkg::*;

  localparam int unsigned LW = cnt_width(FLAG_LAG);

  sfw_state_e    st_q, st_d;
  logic [LW-1:0] gcnt_q, gcnt_d;
  logic          thr_q, thr_d;
  logic [1:0]    addr_q;

  always_comb begin
    st_d   = st_q;
    gcnt_d = gcnt_q;
    thr_d  = thr_q;
    unique case (st_q)
      ST_RUN: begin
        if (buf_end) begin
          st_d   = ST_GUARD;
          gcnt_d = LW'(FLAG_LAG);
          thr_d  = ilv_en ? ~thr_q : 1'b0;
        end
      end
      ST_GUARD: begin
        if (gcnt_q == '0) st_d = ST_RUN;
        else              gcnt_d = gcnt_q - 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      gcnt_q <= '0;
      thr_q  <= 1'b0;
      addr_q <= 2'b00;
    end else begin
      st_q   <= st_d;
      gcnt_q <= gcnt_d;
      thr_q  <= thr_d;
      addr_q <= {1'b0, thr_q};
    end
  end

  assign run  = (st_q == ST_RUN);
  assign addr = addr_q;

  // R7: a closed buffer is always followed by a guard cycle
  p_guard_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end |=> !run);
  // R8: interleave flips the thread at each buffer end
  p_ilv_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && ilv_en) |=> (thr_q != $past(thr_q)));
  // R8: single-thread mode returns to thread 0
  p_single_thr0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && !ilv_en) |=> !thr_q);
endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_BYTES = 64512,
  parameter int unsigned FLAG_LAG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              ilv_en,
  input  logic              link_rdy,
  input  logic              flag_n,
  output logic              cs_n,
  output logic              wr_n,
  output logic              oe_n,
  output logic              rd_n,
  output logic              pktend_n,
  output logic [1:0]        addr,
  output logic [DATA_W-1:0] fd
);
  localparam int unsigned LANE_W    = (DATA_W >= 8) ? 8 : DATA_W;
  localparam int unsigned LANES     = DATA_W / LANE_W;
  localparam int unsigned BUF_WORDS = (BUF_BYTES * 8) / DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic run, acc, buf_end, short_end;
  logic wr_n_d, cs_n_d, pkt_n_d;
  logic wr_n_q, cs_n_q, pkt_n_q;

  sfw_buf_ctr #(.BUF_WORDS(BUF_WORDS)) i_buf_ctr (
    .clk(clk), .rst_n(rst_n_s), .acc(acc), .last_in(s_last),
    .buf_end(buf_end), .short_end(short_end)
  );

  sfw_thread_sel #(.FLAG_LAG(FLAG_LAG)) i_thread_sel (
    .clk(clk), .rst_n(rst_n_s), .buf_end(buf_end), .ilv_en(ilv_en),
    .run(run), .addr(addr)
  );

  assign s_ready = run && link_rdy && !flag_n;
  assign acc     = s_ready && s_valid;

  always_comb begin
    wr_n_d  = !acc;
    cs_n_d  = !acc;
    pkt_n_d = !short_end;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_n_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      pkt_n_q <= 1'b1;
    end else begin
      wr_n_q  <= wr_n_d;
      cs_n_q  <= cs_n_d;
      pkt_n_q <= pkt_n_d;
    end
  end

  // data register per byte lane, loaded only on accept
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) lane_q <= '0;
      else if (acc) lane_q <= s_data[ln*LANE_W +: LANE_W];
    end
    assign fd[ln*LANE_W +: LANE_W] = lane_q;
  end

  assign wr_n     = wr_n_q;
  assign cs_n     = cs_n_q;
  assign pktend_n = pkt_n_q;
  assign oe_n     = 1'b1;
  assign rd_n     = 1'b1;

  // R3: every write strobe follows a cycle with the flag showing ready
  p_flag_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_n |-> !$past(flag_n));
  // R4: every write strobe follows a cycle with the link up
  p_link_gate_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_n |-> $past(link_rdy));
  // R5: select accompanies each write
  p_cs_with_wr_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_n |-> !cs_n);
  // R6: packet end only on a write, and only for one cycle
  p_pkt_on_wr_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !pktend_n |-> !wr_n);
  p_pkt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !pktend_n |=> pktend_n);
  // R8: address holds across back-to-back writes
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_n && !$past(wr_n)) |-> $stable(addr));
endmodule

// File: tb/test_sfifo_wr_master.sv
module test_sfifo_wr_master;
  localparam int DW  = 32;
  localparam int BB  = 32;           // 8 words per buffer
  localparam int LAG = 2;
  localparam int BW  = BB * 8 / DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, ilv_en = 1'b0, link_rdy = 1'b0, flag_n = 1'b1;
  logic [DW-1:0] s_data = '0;
  logic s_ready, cs_n, wr_n, oe_n, rd_n, pktend_n;
  logic [1:0] addr;
  logic [DW-1:0] fd;

  always #5 clk = ~clk;

  sfifo_wr_master #(.DATA_W(DW), .BUF_BYTES(BB), .FLAG_LAG(LAG)) i_sfifo_wr_master (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .ilv_en(ilv_en), .link_rdy(link_rdy), .flag_n(flag_n),
    .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n), .rd_n(rd_n), .pktend_n(pktend_n),
    .addr(addr), .fd(fd)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int g = 0, wcnt = 0;
  logic thr = 1'b0;
  logic [1:0] addr_exp = 2'b00;
  bit p_hs = 0, p_full = 0;
  logic p_pkt_n = 1'b1;
  logic [DW-1:0] p_data = '0;

  function automatic bit exp_ready(input int gg, input logic lk, input logic f);
    return (gg == 0) && lk && !f;
  endfunction

  function automatic logic exp_pkt_n(input int wc, input logic l);
    return !(l && (wc != BW - 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic l,
                      input logic f, input logic lk);
    bit er;
    string tag;
    @(negedge clk);
    if (p_hs) begin
      chk(wr_n == 1'b0, "R5", "wr_n on accepted word", 32'(wr_n), 0);
      chk(cs_n == 1'b0, "R5", "cs_n on accepted word", 32'(cs_n), 0);
      chk(fd == p_data, "R5", "bus data order", fd, p_data);
      chk(pktend_n == p_pkt_n, p_full ? "R9" : "R6", "pktend_n", 32'(pktend_n), 32'(p_pkt_n));
    end else begin
      chk(wr_n == 1'b1, "R3", "wr_n idle", 32'(wr_n), 1);
      chk(pktend_n == 1'b1, "R6", "pktend_n idle", 32'(pktend_n), 1);
    end
    chk(addr == addr_exp, "R8", "thread address", 32'(addr), 32'(addr_exp));
    chk(oe_n && rd_n, "R2", "oe_n/rd_n high", {30'd0, oe_n, rd_n}, 3);
    addr_exp = {1'b0, thr};
    s_valid = v; s_data = d; s_last = l; flag_n = f; link_rdy = lk;
    #1;
    er = exp_ready(g, lk, f);
    if (g != 0)      tag = "R7";
    else if (!lk)    tag = "R4";
    else if (f)      tag = "R3";
    else             tag = "R5";
    chk(s_ready == er, tag, "s_ready", 32'(s_ready), 32'(er));
    if (g != 0) g--;
    p_hs = er && v;
    if (p_hs) begin
      p_data  = d;
      p_pkt_n = exp_pkt_n(wcnt, l);
      p_full  = (wcnt == BW - 1);
      if (p_full || l) begin
        wcnt = 0;
        g = LAG + 1;
        thr = ilv_en ? ~thr : 1'b0;
      end else wcnt++;
    end
  endtask

  task automatic rand_phase(input int cycles);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 10) < 8, DW'($urandom), ($urandom % 10) == 0,
           ($urandom % 100) < 15, ($urandom % 100) >= 5);
  endtask

  initial begin
    void'($urandom(32'd4021));
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk(wr_n && cs_n && pktend_n, "R1", "strobes in reset", {29'd0, wr_n, cs_n, pktend_n}, 7);
    chk(addr == 2'b00, "R1", "addr in reset", 32'(addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr_n && cs_n && pktend_n, "R1", "strobes after reset", {29'd0, wr_n, cs_n, pktend_n}, 7);
    chk(addr == 2'b00, "R1", "addr after reset", 32'(addr), 0);

    // R4: link down blocks a ready flag
    for (int i = 0; i < 4; i++) step(1'b1, DW'(32'hA000 + i), 1'b0, 1'b0, 1'b0);

    ilv_en = 1'b0;
    rand_phase(1500);
    ilv_en = 1'b1;
    rand_phase(1500);

    // directed: close current buffer, then a full buffer with s_last on the final word (R9)
    while (!p_hs || wcnt != 0) step(1'b1, DW'($urandom), 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < LAG + 1; i++) step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b1); // R7 window
    for (int k = 0; k < BW; k++) step(1'b1, DW'(32'hB000 + k), k == BW - 1, 1'b0, 1'b1);
    for (int i = 0; i < LAG + 1; i++) step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b1);
    // R6: single-word short buffer, then flag pause mid-buffer (R3)
    step(1'b1, DW'(32'hC001), 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < LAG + 1; i++) step(1'b1, DW'($urandom), 1'b0, 1'b0, 1'b1);
    step(1'b1, DW'(32'hD000), 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, DW'(32'hDEAD), 1'b0, 1'b1, 1'b1);
    step(1'b1, DW'(32'hD001), 1'b0, 1'b0, 1'b1);
    ilv_en = 1'b0;
    rand_phase(400);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule